// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block derives the periodic interrupt of a real-time clock from a 32.768 kHz time base. The time base arrives as a one-clock strobe, `tick_i`. A 4-bit rate selector and an enable bit come in as plain control levels from the clock's control registers. A binary divider counts the time-base strobes. The block fires whenever the enabled period completes. When it fires, it emits a one-cycle flag-set strobe that carries the status bits to OR into the status register, together with an interrupt raise pulse.

Expiries are taken from a divider that runs freely from reset, so each period is measured from the boundary of the previous one. A late or changed setting never adds drift. Changing the rate simply lets the next boundary of the new period fire.

None of the interfaces carries a data stream, so there is no valid/ready pair and no back-pressure. `tick_i` is a bare strobe that is never stalled. The register file must accept `flag_set_o` and `irq_raise_o` in the cycle they are high, because they are not held.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, `flag_set_o`, `irq_raise_o` are low and `flags_o` is 0, and the divider count starts from zero.
- R2: A rate selector of 0 produces no expiry, whatever the enable.
- R3: With `pie_en_i` low, no expiry occurs for any rate selector.
- R4: For a selector value c from 3 to 15, the period is 2^(c-1) time-base strobes: 3 gives 4 strobes and 15 gives 16384.
- R5: Selectors 1 and 2 are first raised by 7, giving periods of 128 and 256 strobes.
- R6: Expiries fall on the strobes whose index since reset, counting from 1, is a multiple of the period. A change of selector therefore fires at the next boundary of the new period, and no drift builds up.
- R7: An expiry drives `flag_set_o` and `irq_raise_o` high together for exactly one clock. In that clock `flags_o` is 0xC0: bit 7 is the interrupt-request flag and bit 6 is the periodic flag. `flags_o` is 0 in every other clock.
- R8: The outputs rise in the clock after the edge that samples the expiring `tick_i`. No expiry occurs without a strobe.
- R9: Clearing `pie_en_i` suppresses the expiry at once, including one due on the same strobe, and restoring it resumes on the original boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 32.768 kHz time-base strobe |
| rate_code_i | input | 4 | Periodic rate selector, 0 = off |
| pie_en_i | input | 1 | Periodic interrupt enable |
| flag_set_o | output | 1 | One-cycle strobe: OR `flags_o` into the status register |
| flags_o | output | 8 | Status bits to set (0xC0 on expiry) |
| irq_raise_o | output | 1 | One-cycle interrupt raise pulse |

## Verification
The hardest case to reach is the longest period, selector 15. It needs 16384 strobes before a single expiry, and the count must be reached across earlier scenarios without losing the divider's phase. The bench keeps its own running count of strobes from reset and drives every strobe itself. That lets it predict each boundary as selectors change part-way through a period, when the enable drops on the very strobe that would fire, and during the long final run.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // selectors at or below this value (and nonzero) are moved up
  localparam int unsigned REMAP_MAX = 2;
  localparam int unsigned REMAP_ADD = 7;
  localparam logic [7:0]  FIRE_FLAGS = 8'hC0; // bit7 request, bit6 periodic

  function automatic logic [3:0] eff_code(input logic [3:0] code);
    if (code != 4'd0 && int'(code) <= REMAP_MAX)
      return code + 4'(REMAP_ADD);
    return code;
  endfunction
endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 14
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  mask_o
);
  import pirq_pkg::*;

  logic [CODE_W-1:0] eff;
  assign eff      = eff_code(code_i);
  assign active_o = (code_i != '0);

  // period = 1 << (eff-1); mask has the low eff-1 bits set
  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign mask_o[i] = (int'(eff) > i + 1);
    end
  endgenerate
endmodule

// File: rtl/pirq_tick_div.sv
module pirq_tick_div #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  // R6
  div_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  // R6
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pirq_fire.sv
module pirq_fire #(
  parameter int CNT_W  = 14,
  parameter int FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  mask_i,
  output logic              flag_set_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_raise_o
);
  import pirq_pkg::*;

  logic fire;
  assign fire = tick_i && run_i && ((cnt_i & mask_i) == mask_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flag_set_o  <= 1'b0;
      irq_raise_o <= 1'b0;
      flags_o     <= '0;
    end else begin
      flag_set_o  <= fire;
      irq_raise_o <= fire;
      flags_o     <= fire ? FLAG_W'(FIRE_FLAGS) : '0;
    end
  end

  // R8
  fire_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_o |-> $past(tick_i));
  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_o |=> !flag_set_o);
  // R7
  flags_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raise_o |-> flags_o == FLAG_W'(FIRE_FLAGS));
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int CODE_W = 4,
  parameter int FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              pie_en_i,
  output logic              flag_set_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_raise_o
);
  // longest period is 1 << (2^CODE_W - 2) strobes
  localparam int CNT_W = (1 << CODE_W) - 2;

  logic             active;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt;

  pirq_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .code_i(rate_code_i), .active_o(active), .mask_o(mask));

  pirq_tick_div #(.CNT_W(CNT_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_o(cnt));

  pirq_fire #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_fire (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .run_i(active && pie_en_i), .cnt_i(cnt), .mask_i(mask),
    .flag_set_o(flag_set_o), .flags_o(flags_o), .irq_raise_o(irq_raise_o));

  // R2 R3 R9
  gated_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_o |-> ($past(pie_en_i) && $past(rate_code_i) != '0));
endmodule

// File: tb/sim_periodic_irq_gen.sv
`timescale 1ns/1ps
module sim_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] code = 4'd0;
  logic       pie = 1'b0;
  logic       flag_set, irq_raise;
  logic [7:0] flags;

  int tests = 0;
  int fails = 0;
  int ntick = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  periodic_irq_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_code_i(code),
    .pie_en_i(pie), .flag_set_o(flag_set), .flags_o(flags),
    .irq_raise_o(irq_raise));

  function automatic int period_of(input logic [3:0] c);
    if (c == 4'd1) return 128;   // R5
    if (c == 4'd2) return 256;   // R5
    return 1 << (int'(c) - 1);   // R4
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (tick %0d code %0d)",
               req, act, exp, ntick, code);
    end
  endtask

  // one strobe, check the result cycle and the cycle after it
  task automatic do_tick(input string req);
    bit exp;
    int p;
    p = period_of(code);
    exp = pie && (code != 4'd0) && ((ntick % p) == p - 1);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    ntick++;
    chk(req, {flag_set, irq_raise, flags}, exp ? 10'h3C0 : 10'h000);
    @(negedge clk);
    chk("R7", {flag_set, irq_raise, flags}, 10'h000);
  endtask

  task automatic run_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) do_tick(req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", {flag_set, irq_raise, flags}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {flag_set, irq_raise, flags}, 0);
  endtask

  task automatic t_code_zero;
    code = 4'd0; pie = 1'b1;
    run_ticks(40, "R2");
  endtask

  task automatic t_pie_off;
    pie = 1'b0;
    for (int c = 1; c < 16; c++) begin
      code = 4'(c);
      run_ticks(8, "R3");
    end
  endtask

  task automatic t_rates;
    pie = 1'b1;
    for (int c = 3; c <= 9; c++) begin
      code = 4'(c);
      run_ticks(2 * period_of(code), "R4");
    end
  endtask

  task automatic t_remap;
    code = 4'd1; run_ticks(300, "R5");
    code = 4'd2; run_ticks(600, "R5");
  endtask

  task automatic t_realign;
    code = 4'd6;
    while ((ntick % 32) != 13) do_tick("R6");
    code = 4'd3;  // next 4-strobe boundary fires
    run_ticks(12, "R6");
    code = 4'd5;
    run_ticks(40, "R6");
  endtask

  task automatic t_pie_clear;
    code = 4'd4;
    while ((ntick % 8) != 7) do_tick("R9");
    pie = 1'b0;   // the strobe due to fire is suppressed
    run_ticks(17, "R9");
    pie = 1'b1;
    run_ticks(24, "R9");
  endtask

  task automatic t_no_tick;
    code = 4'd3;
    while ((ntick % 4) != 3) do_tick("R8");
    repeat (20) begin
      @(negedge clk);
      chk("R8", {flag_set, irq_raise}, 0);
    end
    do_tick("R8");
  endtask

  task automatic t_slow;
    code = 4'd15;
    run_ticks(16400, "R4");
  endtask

  initial begin
    t_reset();
    t_code_zero();
    t_pie_off();
    t_rates();
    t_remap();
    t_realign();
    t_pie_clear();
    t_no_tick();
    t_slow();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule